// File: doc/BRIEF.md
# MSI Forwarding Scanner and Generator

This block turns pending interrupt sources into message-signalled interrupts. Every source has a 32-bit routing word. The low field of that word is the interrupt identity written to the receiver, the middle field is the guest index and the top field is the hart index. When a source is both enabled and pending, and the domain-wide enable is high, the block can forward it. Forwarding places one message on a valid/ready output and clears the source's pending flag.

Two paths lead to forwarding. A rescan request starts an ordered walk that visits sources 1 to NSRC-1 and forwards every eligible source it meets. This is how pending work is collected after a configuration write. An event request names a single source and is served at once, ahead of the walk.

A software generation register sends one message by itself. Its hart index and identity come from the written word, and its guest index is forced to zero. The register reads back the written word with the guest field cleared. Source 0 is reserved. It never becomes pending, and messages sent from the generation register carry source tag 0.

Top module: `msi_fwd_scan`

## Requirements
- R1: A forwarded message takes its fields from the source's routing word. Bits [EIID_W-1:0] give msg_eiid, the next GUEST_W bits give msg_guest, and the top HART_W bits give msg_hart. With the defaults these are [10:0], [16:11] and [31:17]. msg_src carries the source number.
- R2: While `ie` is low, no message with a nonzero msg_src is issued, from either the walk or an event, and pending flags stay as they are.
- R3: After a one-cycle `scan_req`, the walk visits sources 1 through NSRC-1 in ascending order. It forwards exactly the sources that are enabled and pending, in ascending source order. Disabled sources stay pending.
- R4: A forwarded source has its pending flag cleared. This is visible on `pend_vec` in the same cycle its message first appears on the output, unless `pend_set` set the flag again in the issuing cycle.
- R5: A `gen_we` write sends exactly one message. Its msg_src is 0, msg_guest is 0, msg_hart is the top HART_W bits of the written word and msg_eiid is the low EIID_W bits.
- R6: The cycle after a `gen_we` write, `gen_rdata` equals the written word with the guest field (default bits [16:11]) cleared.
- R7: At most one message is issued per cycle. While `msg_valid` is high and `msg_ready` is low, all message outputs hold steady. The walk pauses at its position and loses no eligible source.
- R8: Issue priority is: generation register first, then event request, then walk. `evt_take` is high only in a cycle where `evt_req` is accepted, and it stays low while a generated message is waiting.
- R9: A `scan_req` that arrives during a walk restarts the walk from source 1.
- R10: `pend_set` sets flags, `pend_clr` clears them, and bit 0 of `pend_vec` is always 0. An accepted event request for source 0, or for a source that is disabled or not pending, sends nothing and leaves `pend_vec` unchanged.
- R11: After reset, `msg_valid`, `pend_vec`, `gen_rdata` and `evt_take` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ie | input | 1 | Domain-wide forwarding enable |
| src_en | input | NSRC | Per-source enable |
| src_target | input | NSRC*TGT_W | Routing words, source s at bits [s*TGT_W +: TGT_W] |
| pend_set | input | NSRC | Set pending flags |
| pend_clr | input | NSRC | Clear pending flags |
| pend_vec | output | NSRC | Current pending flags |
| scan_req | input | 1 | Start or restart the ordered walk |
| evt_req | input | 1 | Immediate forward request, held until taken |
| evt_idx | input | SRC_W | Source named by the event request |
| evt_take | output | 1 | Event request accepted this cycle |
| gen_we | input | 1 | Write the generation register |
| gen_wdata | input | TGT_W | Word written to the generation register |
| gen_rdata | output | TGT_W | Generation register read-back |
| msg_valid | output | 1 | Message present |
| msg_ready | input | 1 | Receiver accepts the message |
| msg_src | output | SRC_W | Source number (0 for generated) |
| msg_hart | output | HART_W | Hart index |
| msg_guest | output | GUEST_W | Guest index |
| msg_eiid | output | EIID_W | Interrupt identity |

## Verification
The bench uses the default build: eight sources and an 11/6/15 split of the routing word. A full walk therefore takes seven visits. A stall, a restart in the middle of a walk and an event that overtakes the walk can each be set up within a few dozen cycles. The field boundaries do not fall on nibble edges, and each source gets distinct field values, so a shifted or overlapping field shows up in the message contents. The stimulus table covers enable and pending patterns together with the state of the domain enable.

// File: rtl/msi_fwd_pkg.sv
package msi_fwd_pkg;
    typedef enum logic [1:0] {
        ISS_NONE,
        ISS_GEN,
        ISS_EVT,
        ISS_WALK
    } iss_kind_e;
endpackage

// File: rtl/msi_fwd_pend.sv
module msi_fwd_pend #(
    parameter int NSRC = 8,
    localparam int SRC_W = $clog2(NSRC)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NSRC-1:0]  set_vec,
    input  logic [NSRC-1:0]  clr_vec,
    input  logic             hit,
    input  logic [SRC_W-1:0] hit_idx,
    output logic [NSRC-1:0]  pend_vec
);
    typedef struct packed {
        logic [NSRC-1:0] pend;
    } pend_st_t;

    pend_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        st_d.pend = st_q.pend & ~clr_vec;
        if (hit) begin
            st_d.pend[hit_idx] = 1'b0;
        end
        st_d.pend = st_d.pend | set_vec;
        st_d.pend[0] = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pend_vec = st_q.pend;
endmodule

// File: rtl/msi_fwd_walk.sv
module msi_fwd_walk #(
    parameter int NSRC = 8,
    localparam int SRC_W = $clog2(NSRC)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic             step,
    output logic             active,
    output logic [SRC_W-1:0] cur
);
    localparam logic [SRC_W-1:0] LAST = SRC_W'(NSRC - 1);

    typedef struct packed {
        logic             active;
        logic [SRC_W-1:0] cur;
    } walk_st_t;

    walk_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (restart) begin
            st_d.active = 1'b1;
            st_d.cur    = SRC_W'(1);
        end else if (step) begin
            if (st_q.cur == LAST) begin
                st_d.active = 1'b0;
            end else begin
                st_d.cur = st_q.cur + SRC_W'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign active = st_q.active;
    assign cur    = st_q.cur;
endmodule

// File: rtl/msi_fwd_scan.sv
module msi_fwd_scan
    import msi_fwd_pkg::*;
#(
    parameter int NSRC    = 8,
    parameter int EIID_W  = 11,
    parameter int GUEST_W = 6,
    parameter int HART_W  = 15,
    localparam int TGT_W  = EIID_W + GUEST_W + HART_W,
    localparam int SRC_W  = $clog2(NSRC)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  ie,
    input  logic [NSRC-1:0]       src_en,
    input  logic [NSRC*TGT_W-1:0] src_target,
    input  logic [NSRC-1:0]       pend_set,
    input  logic [NSRC-1:0]       pend_clr,
    output logic [NSRC-1:0]       pend_vec,
    input  logic                  scan_req,
    input  logic                  evt_req,
    input  logic [SRC_W-1:0]      evt_idx,
    output logic                  evt_take,
    input  logic                  gen_we,
    input  logic [TGT_W-1:0]      gen_wdata,
    output logic [TGT_W-1:0]      gen_rdata,
    output logic                  msg_valid,
    input  logic                  msg_ready,
    output logic [SRC_W-1:0]      msg_src,
    output logic [HART_W-1:0]     msg_hart,
    output logic [GUEST_W-1:0]    msg_guest,
    output logic [EIID_W-1:0]     msg_eiid
);
    localparam int GUEST_LSB = EIID_W;
    localparam int HART_LSB  = EIID_W + GUEST_W;
    localparam logic [TGT_W-1:0] GUEST_MASK =
        {{(TGT_W-GUEST_W){1'b0}}, {GUEST_W{1'b1}}} << GUEST_LSB;

    typedef struct packed {
        logic               valid;
        logic [SRC_W-1:0]   src;
        logic [HART_W-1:0]  hart;
        logic [GUEST_W-1:0] guest;
        logic [EIID_W-1:0]  eiid;
        logic [TGT_W-1:0]   gen_word;
        logic               gen_pend;
    } top_st_t;

    top_st_t st_d, st_q;

    iss_kind_e        kind;
    logic             slot_free;
    logic             walk_active;
    logic [SRC_W-1:0] walk_cur;
    logic             evt_ok;
    logic             walk_ok;
    logic             fwd_hit;
    logic [SRC_W-1:0] fwd_idx;
    logic [TGT_W-1:0] tgt_word;

    msi_fwd_pend #(.NSRC(NSRC)) u_pend (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_vec  (pend_set),
        .clr_vec  (pend_clr),
        .hit      (fwd_hit),
        .hit_idx  (fwd_idx),
        .pend_vec (pend_vec)
    );

    msi_fwd_walk #(.NSRC(NSRC)) u_walk (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (scan_req),
        .step    (kind == ISS_WALK),
        .active  (walk_active),
        .cur     (walk_cur)
    );

    always_comb begin
        slot_free = !st_q.valid || msg_ready;
        if (st_q.gen_pend && slot_free) begin
            kind = ISS_GEN;
        end else if (evt_req && slot_free) begin
            kind = ISS_EVT;
        end else if (walk_active && slot_free && !scan_req) begin
            kind = ISS_WALK;
        end else begin
            kind = ISS_NONE;
        end

        evt_ok  = ie && (evt_idx != '0) && (int'(evt_idx) < NSRC)
                  && src_en[evt_idx] && pend_vec[evt_idx];
        walk_ok = ie && src_en[walk_cur] && pend_vec[walk_cur];
        fwd_hit = ((kind == ISS_EVT) && evt_ok) || ((kind == ISS_WALK) && walk_ok);
        fwd_idx = (kind == ISS_EVT) ? evt_idx : walk_cur;
        tgt_word = src_target[int'(fwd_idx)*TGT_W +: TGT_W];

        st_d = st_q;
        if (slot_free) begin
            st_d.valid = 1'b0;
        end
        if (fwd_hit) begin
            st_d.valid = 1'b1;
            st_d.src   = fwd_idx;
            st_d.hart  = tgt_word[HART_LSB +: HART_W];
            st_d.guest = tgt_word[GUEST_LSB +: GUEST_W];
            st_d.eiid  = tgt_word[EIID_W-1:0];
        end
        if (kind == ISS_GEN) begin
            st_d.valid    = 1'b1;
            st_d.src      = '0;
            st_d.hart     = st_q.gen_word[HART_LSB +: HART_W];
            st_d.guest    = '0;
            st_d.eiid     = st_q.gen_word[EIID_W-1:0];
            st_d.gen_pend = 1'b0;
        end
        if (gen_we) begin
            st_d.gen_word = gen_wdata & ~GUEST_MASK;
            st_d.gen_pend = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign evt_take  = (kind == ISS_EVT);
    assign gen_rdata = st_q.gen_word;
    assign msg_valid = st_q.valid;
    assign msg_src   = st_q.src;
    assign msg_hart  = st_q.hart;
    assign msg_guest = st_q.guest;
    assign msg_eiid  = st_q.eiid;
endmodule

// File: rtl/msi_fwd_scan_chk.sv
module msi_fwd_scan_chk #(
    parameter int NSRC    = 8,
    parameter int EIID_W  = 11,
    parameter int GUEST_W = 6,
    parameter int HART_W  = 15,
    localparam int TGT_W  = EIID_W + GUEST_W + HART_W,
    localparam int SRC_W  = $clog2(NSRC)
) (
    input logic               clk,
    input logic               rst_n,
    input logic               ie,
    input logic [NSRC-1:0]    pend_set,
    input logic [NSRC-1:0]    pend_vec,
    input logic               evt_req,
    input logic               evt_take,
    input logic               gen_we,
    input logic [TGT_W-1:0]   gen_wdata,
    input logic [TGT_W-1:0]   gen_rdata,
    input logic               msg_valid,
    input logic               msg_ready,
    input logic [SRC_W-1:0]   msg_src,
    input logic [HART_W-1:0]  msg_hart,
    input logic [GUEST_W-1:0] msg_guest,
    input logic [EIID_W-1:0]  msg_eiid
);
    localparam logic [TGT_W-1:0] GMASK =
        {{(TGT_W-GUEST_W){1'b0}}, {GUEST_W{1'b1}}} << EIID_W;

    AST_HOLD_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        msg_valid && !msg_ready |=> msg_valid && $stable({msg_src, msg_hart, msg_guest, msg_eiid})); // R7

    AST_IE_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        !ie && (!msg_valid || msg_ready) |=> !(msg_valid && msg_src != '0)); // R2

    AST_FWD_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (!msg_valid || msg_ready) |=> (!(msg_valid && msg_src != '0) || !pend_vec[msg_src] || $past(pend_set[msg_src]))); // R4

    AST_SW_GUEST_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        msg_valid && msg_src == '0 |-> msg_guest == '0); // R5

    AST_GEN_READBACK: assert property (@(posedge clk) disable iff (!rst_n)
        gen_we |=> gen_rdata == ($past(gen_wdata) & ~GMASK)); // R6

    AST_TAKE_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        evt_take |-> evt_req); // R8

    AST_NO_SRC0_PEND: assert property (@(posedge clk) disable iff (!rst_n)
        !pend_vec[0]); // R10
endmodule

bind msi_fwd_scan msi_fwd_scan_chk #(
    .NSRC(NSRC), .EIID_W(EIID_W), .GUEST_W(GUEST_W), .HART_W(HART_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .ie(ie), .pend_set(pend_set), .pend_vec(pend_vec),
    .evt_req(evt_req), .evt_take(evt_take), .gen_we(gen_we), .gen_wdata(gen_wdata),
    .gen_rdata(gen_rdata), .msg_valid(msg_valid), .msg_ready(msg_ready),
    .msg_src(msg_src), .msg_hart(msg_hart), .msg_guest(msg_guest), .msg_eiid(msg_eiid)
);

// File: tb/msi_fwd_scan_tb.sv
module msi_fwd_scan_tb;
    localparam int N  = 8;
    localparam int EW = 11;
    localparam int GW = 6;
    localparam int HW = 15;
    localparam int TW = EW + GW + HW;
    localparam int SW = $clog2(N);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ie = 1'b0;
    logic [N-1:0] src_en = '0;
    logic [N*TW-1:0] src_target;
    logic [N-1:0] pend_set = '0;
    logic [N-1:0] pend_clr = '0;
    logic [N-1:0] pend_vec;
    logic scan_req = 1'b0;
    logic evt_req = 1'b0;
    logic [SW-1:0] evt_idx = '0;
    logic evt_take;
    logic gen_we = 1'b0;
    logic [TW-1:0] gen_wdata = '0;
    logic [TW-1:0] gen_rdata;
    logic msg_valid;
    logic msg_ready = 1'b1;
    logic [SW-1:0] msg_src;
    logic [HW-1:0] msg_hart;
    logic [GW-1:0] msg_guest;
    logic [EW-1:0] msg_eiid;

    int total = 0;
    int bad = 0;
    int q_src[$];
    int q_hart[$];
    int q_guest[$];
    int q_eiid[$];

    // {ie, enable mask, pending mask}
    localparam logic [16:0] VEC [0:5] = '{
        {1'b1, 8'hFF, 8'hAA},
        {1'b1, 8'h0F, 8'hFF},
        {1'b0, 8'hFF, 8'hFF},
        {1'b1, 8'h81, 8'h81},
        {1'b1, 8'hF0, 8'h3C},
        {1'b1, 8'h00, 8'hFF}
    };

    always #4 clk = ~clk;

    msi_fwd_scan u_dut (
        .clk(clk), .rst_n(rst_n), .ie(ie), .src_en(src_en), .src_target(src_target),
        .pend_set(pend_set), .pend_clr(pend_clr), .pend_vec(pend_vec),
        .scan_req(scan_req), .evt_req(evt_req), .evt_idx(evt_idx), .evt_take(evt_take),
        .gen_we(gen_we), .gen_wdata(gen_wdata), .gen_rdata(gen_rdata),
        .msg_valid(msg_valid), .msg_ready(msg_ready), .msg_src(msg_src),
        .msg_hart(msg_hart), .msg_guest(msg_guest), .msg_eiid(msg_eiid)
    );

    function automatic logic [TW-1:0] tgt_of(int s);
        return {HW'(s*1000+5), GW'(s+40), EW'(s*100+9)};
    endfunction

    initial begin
        for (int s = 0; s < N; s++) src_target[s*TW +: TW] = tgt_of(s);
    end

    always @(negedge clk) begin
        if (rst_n && msg_valid && msg_ready) begin
            q_src.push_back(int'(msg_src));
            q_hart.push_back(int'(msg_hart));
            q_guest.push_back(int'(msg_guest));
            q_eiid.push_back(int'(msg_eiid));
        end
    end

    task automatic tick(int n);
        repeat (n) begin
            @(posedge clk);
            #1;
        end
    endtask

    task automatic chk(string req, string what, longint act, longint exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic flush();
        q_src.delete(); q_hart.delete(); q_guest.delete(); q_eiid.delete();
    endtask

    task automatic check_seq(string req, int exp[$]);
        chk(req, "message count", q_src.size(), exp.size());
        for (int i = 0; i < exp.size() && i < q_src.size(); i++) begin
            chk(req, "source order", q_src[i], exp[i]);
            if (exp[i] != 0) begin
                logic [TW-1:0] w;
                w = tgt_of(exp[i]);
                chk("R1", "hart field", q_hart[i], w[TW-1 -: HW]);
                chk("R1", "guest field", q_guest[i], w[EW +: GW]);
                chk("R1", "eiid field", q_eiid[i], w[EW-1:0]);
            end
        end
    endtask

    task automatic clear_all();
        src_en = '0; pend_clr = '1; evt_req = 1'b0;
        tick(1);
        pend_clr = '0;
        tick(2);
        flush();
    endtask

    task automatic setup(logic e, logic [N-1:0] en, logic [N-1:0] pd);
        ie = e; src_en = en; pend_set = pd;
        tick(1);
        pend_set = '0;
    endtask

    task automatic scan();
        scan_req = 1'b1;
        tick(1);
        scan_req = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int exp[$];
        logic [TW-1:0] w;
        tick(3);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R11", "msg_valid after reset", msg_valid, 0);
        chk("R11", "pend_vec after reset", pend_vec, 0);
        chk("R11", "gen_rdata after reset", gen_rdata, 0);
        chk("R11", "evt_take after reset", evt_take, 0);

        // table of walk scenarios: R1 R2 R3 R4 R10
        for (int v = 0; v < 6; v++) begin
            logic vie;
            logic [7:0] ven, vpd, epd;
            {vie, ven, vpd} = VEC[v];
            clear_all();
            setup(vie, ven, vpd);
            scan();
            tick(12);
            exp.delete();
            for (int s = 1; s < N; s++) if (vie && ven[s] && vpd[s]) exp.push_back(s);
            check_seq(vie ? "R3" : "R2", exp);
            epd = vie ? (vpd & ~ven & 8'hFE) : (vpd & 8'hFE);
            @(negedge clk);
            chk(vie ? "R4" : "R2", "pend_vec after walk", pend_vec, epd);
            chk("R10", "source 0 never pending", pend_vec[0], 0);
        end

        // R5 R6 generation register
        clear_all();
        for (int k = 0; k < 2; k++) begin
            w = (k == 0) ? 32'hFFFF_FFFF : 32'h1234_5678;
            gen_wdata = w; gen_we = 1'b1;
            tick(1);
            gen_we = 1'b0;
            @(negedge clk);
            chk("R6", "gen readback", gen_rdata, w & ~(32'h3F << EW));
            tick(3);
            chk("R5", "one generated message", q_src.size(), 1);
            if (q_src.size() > 0) begin
                chk("R5", "gen source tag", q_src[0], 0);
                chk("R5", "gen guest", q_guest[0], 0);
                chk("R5", "gen hart", q_hart[0], w[TW-1 -: HW]);
                chk("R5", "gen eiid", q_eiid[0], w[EW-1:0]);
            end
            flush();
        end

        // R7 stall holds message and walk position
        clear_all();
        msg_ready = 1'b0;
        setup(1'b1, 8'hFF, 8'h24);
        scan();
        tick(8);
        @(negedge clk);
        chk("R7", "stalled valid", msg_valid, 1);
        chk("R7", "stalled source", msg_src, 2);
        chk("R7", "later source still pending", pend_vec, 8'h20);
        tick(3);
        @(negedge clk);
        chk("R7", "held source", msg_src, 2);
        msg_ready = 1'b1;
        tick(10);
        exp = '{2, 5};
        check_seq("R7", exp);

        // R8 event overtakes walk
        clear_all();
        msg_ready = 1'b0;
        setup(1'b1, 8'hFF, 8'h4C);
        scan();
        tick(4);
        msg_ready = 1'b1; evt_req = 1'b1; evt_idx = 3'd6;
        @(negedge clk);
        chk("R8", "event taken over walk", evt_take, 1);
        tick(1);
        evt_req = 1'b0;
        tick(10);
        exp = '{2, 6, 3};
        check_seq("R8", exp);

        // R8 generated message beats event
        clear_all();
        setup(1'b1, 8'hFF, 8'h10);
        gen_wdata = 32'h0002_0001; gen_we = 1'b1;
        tick(1);
        gen_we = 1'b0; evt_req = 1'b1; evt_idx = 3'd4;
        @(negedge clk);
        chk("R8", "event waits for generated", evt_take, 0);
        tick(1);
        @(negedge clk);
        chk("R8", "event taken after generated", evt_take, 1);
        tick(1);
        evt_req = 1'b0;
        tick(3);
        exp = '{0, 4};
        check_seq("R8", exp);

        // R9 restart mid-walk
        clear_all();
        setup(1'b1, 8'hFF, 8'h86);
        scan();
        tick(2);
        pend_set = 8'h02;
        tick(1);
        pend_set = '0; scan_req = 1'b1;
        tick(1);
        scan_req = 1'b0;
        tick(12);
        exp = '{1, 2, 1, 7};
        check_seq("R9", exp);

        // R10 dropped events and clear
        clear_all();
        setup(1'b1, 8'hEF, 8'h10);
        evt_req = 1'b1; evt_idx = 3'd4;
        @(negedge clk);
        chk("R10", "ineligible event taken", evt_take, 1);
        tick(1);
        evt_idx = 3'd0;
        tick(1);
        evt_req = 1'b0;
        tick(3);
        exp.delete();
        check_seq("R10", exp);
        @(negedge clk);
        chk("R10", "pending kept after drop", pend_vec, 8'h10);
        pend_clr = 8'h10;
        tick(1);
        pend_clr = '0;
        @(negedge clk);
        chk("R10", "pending cleared", pend_vec, 0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule